// File: doc/BRIEF.md
# Speed Ramp Controller

This block steers an 8-bit speed code toward a requested target one code at a time. The motor therefore never receives a large step in its commanded speed. The speed code goes to a downstream commutation sequencer. A one-cycle strobe loads a new target. A one-cycle millisecond tick sets the pace of the ramp. The block climbs faster than it falls. By default it goes up one code every 10 ticks and down one code every 20 ticks, and both intervals are parameters.

The controller has four named states:

- **IDLE** holds the power-up code `INIT_CODE` until the first target strobe. The transition *start* then leads to COMPARE.
- **COMPARE** checks the current code against the target:
  - *climb* leads to ACCEL when the code is below the target.
  - *descend* leads to DECEL when the code is above the target.
  - *settle* keeps the block in COMPARE when the two are equal. In that case `at_target` is high.
- **ACCEL** and **DECEL** count ticks. When the interval runs out, the transition *step* moves the code by one and returns to COMPARE.
  - A strobe in either state takes the *retarget* transition back to COMPARE.
  - *retarget* throws away any partly counted interval.

Top module: `speed_ramp_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `speed_code` equals `INIT_CODE` and `at_target` is low.
- R2: Before the first strobe on `tgt_valid`, ticks on `ms_tick` leave `speed_code` unchanged and `at_target` low.
- R3: COMPARE goes to ACCEL when the code is below the target and to DECEL when it is above. When the code equals the target, the block stays in COMPARE, and further ticks do not change the code.
- R4: In ACCEL the code rises by exactly 1 on the UP_MS-th tick counted since ACCEL was entered. It never passes the target.
- R5: In DECEL the code falls by exactly 1 on the DOWN_MS-th tick counted since DECEL was entered. It never passes the target.
- R6: The code changes only in a cycle in which `ms_tick` was high, and it changes by exactly one code per change.
- R7: After every step the block is in COMPARE. `at_target` is high exactly when the block is settled in COMPARE with the code equal to the latched target.
- R8: A strobe received in ACCEL or DECEL returns the block to COMPARE. The ticks already counted toward the interval are discarded, so a full new interval is needed before the next step.
- R9: The code never wraps. It stays at 0 and at 2^CODE_W-1 (255) under further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_code | input | CODE_W | Requested speed code |
| tgt_valid | input | 1 | One-cycle strobe that latches `tgt_code` |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| speed_code | output | CODE_W | Current speed code |
| at_target | output | 1 | High when settled at the target |

## Verification
The bench goes after three corner cases:

- **Interval restart on retarget.** A retarget arrives with part of an interval already counted. A design that keeps the stale count steps too early, and the checked code comes out one lower than expected.
- **Asymmetric rates.** The bench separates the two rates by checking the code just before and just after the 10th and 20th tick. Swapped or shared intervals give a wrong code at those points.
- **End codes.** Full ramps are run to 255 and down to 0, and extra ticks follow. A design without saturation wraps around, and one without a target stop overshoots.

A reset during a ramp must bring back the initial code.

// File: rtl/speed_ramp_pkg.sv
package speed_ramp_pkg;
    typedef enum logic [1:0] {
        RS_IDLE    = 2'd0,
        RS_COMPARE = 2'd1,
        RS_ACCEL   = 2'd2,
        RS_DECEL   = 2'd3
    } ramp_state_e;
endpackage

// File: rtl/ramp_interval_timer.sv
module ramp_interval_timer #(
    parameter int UP_MS   = 10,
    parameter int DOWN_MS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_down,
    input  logic tick,
    output logic expire
);
    localparam int MAX_MS = (UP_MS > DOWN_MS) ? UP_MS : DOWN_MS;
    localparam int CNT_W  = $clog2(MAX_MS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_m1;

    always_comb begin
        limit_m1 = sel_down ? CNT_W'(DOWN_MS - 1) : CNT_W'(UP_MS - 1);
        expire   = run && tick && (cnt_q == limit_m1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4/R5: the partial count never reaches the longest interval
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(MAX_MS));

    // R8: the count is cleared while stopped
    p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/ramp_step_unit.sv
module ramp_step_unit #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code,
    input  logic              inc,
    input  logic              dec,
    output logic [CODE_W-1:0] code_nxt
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    always_comb begin
        code_nxt = code;
        if (inc && code != CODE_MAX) begin
            code_nxt = code + 1'b1;
        end else if (dec && code != '0) begin
            code_nxt = code - 1'b1;
        end
    end
endmodule

// File: rtl/speed_ramp_ctrl.sv
module speed_ramp_ctrl
    import speed_ramp_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int UP_MS     = 10,
    parameter int DOWN_MS   = 20,
    parameter int INIT_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] tgt_code,
    input  logic              tgt_valid,
    input  logic              ms_tick,
    output logic [CODE_W-1:0] speed_code,
    output logic              at_target
);
    localparam logic [CODE_W-1:0] INIT_VAL = CODE_W'(INIT_CODE);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    ramp_state_e       state_q, state_d;
    logic [CODE_W-1:0] speed_q, speed_d, tgt_q;
    logic              tmr_run, tmr_expire, step_up, step_dn;

    assign tmr_run = (state_q == RS_ACCEL || state_q == RS_DECEL) && !tgt_valid;
    assign step_up = (state_q == RS_ACCEL) && tmr_expire;
    assign step_dn = (state_q == RS_DECEL) && tmr_expire;

    ramp_interval_timer #(
        .UP_MS   (UP_MS),
        .DOWN_MS (DOWN_MS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tmr_run),
        .sel_down (state_q == RS_DECEL),
        .tick     (ms_tick),
        .expire   (tmr_expire)
    );

    ramp_step_unit #(
        .CODE_W (CODE_W)
    ) u_step (
        .code     (speed_q),
        .inc      (step_up),
        .dec      (step_dn),
        .code_nxt (speed_d)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:    if (tgt_valid) state_d = RS_COMPARE;           // start
            RS_COMPARE: begin
                if (tgt_valid)             state_d = RS_COMPARE;
                else if (speed_q < tgt_q)  state_d = RS_ACCEL;         // climb
                else if (speed_q > tgt_q)  state_d = RS_DECEL;         // descend
                else                       state_d = RS_COMPARE;       // settle
            end
            RS_ACCEL,
            RS_DECEL:   if (tgt_valid || tmr_expire) state_d = RS_COMPARE; // retarget / step
            default:    state_d = RS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            speed_q <= INIT_VAL;
            tgt_q   <= INIT_VAL;
        end else begin
            state_q <= state_d;
            speed_q <= speed_d;
            if (tgt_valid) tgt_q <= tgt_code;
        end
    end

    // outputs
    always_comb begin
        speed_code = speed_q;
        at_target  = (state_q == RS_COMPARE) && (speed_q == tgt_q);
    end

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_IDLE && !tgt_valid) |=> $stable(speed_q));

    p_step_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(speed_q) |-> ($past(ms_tick) &&
            ((speed_q == $past(speed_q) + 1'b1) || (speed_q == $past(speed_q) - 1'b1))));

    p_rise_toward_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_q > $past(speed_q)) |-> ($past(state_q) == RS_ACCEL && $past(speed_q) < $past(tgt_q)));

    p_fall_toward_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_q < $past(speed_q)) |-> ($past(state_q) == RS_DECEL && $past(speed_q) > $past(tgt_q)));

    p_step_then_compare_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(speed_q) |-> state_q == RS_COMPARE);

    p_strobe_recompare_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && state_q != RS_IDLE) |=> state_q == RS_COMPARE);

    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(($past(speed_q) == CODE_MAX && speed_q == '0) ||
          ($past(speed_q) == '0 && speed_q == CODE_MAX)));
endmodule

// File: tb/speed_ramp_ctrl_tb.sv
module speed_ramp_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int INIT       = 5;
    localparam int NROWS      = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tgt_code = '0;
    logic       tgt_valid = 1'b0;
    logic       ms_tick = 1'b0;
    logic [7:0] speed_code;
    logic       at_target;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    speed_ramp_ctrl #(
        .CODE_W (8), .UP_MS (10), .DOWN_MS (20), .INIT_CODE (INIT)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .tgt_code (tgt_code), .tgt_valid (tgt_valid),
        .ms_tick (ms_tick), .speed_code (speed_code), .at_target (at_target)
    );

    // {target, tick count, expected code, expected at_target}
    localparam logic [24:0] VEC [NROWS] = '{
        {8'd8, 8'd25, 8'd7, 1'b0},  // R4 climb two steps
        {8'd8, 8'd15, 8'd8, 1'b1},  // R4 R3 reach and settle
        {8'd8, 8'd30, 8'd8, 1'b1},  // R3 settled, ticks ignored
        {8'd6, 8'd30, 8'd7, 1'b0},  // R5 one step per 20
        {8'd6, 8'd19, 8'd7, 1'b0},  // R8 partial count discarded
        {8'd6, 8'd40, 8'd6, 1'b1},  // R5 reach lower target
        {8'd9, 8'd9,  8'd6, 1'b0},  // R4 nine ticks: no step
        {8'd9, 8'd10, 8'd7, 1'b0},  // R4 tenth tick steps
        {8'd3, 8'd0,  8'd7, 1'b0},  // R7 not settled after retarget
        {8'd3, 8'd20, 8'd6, 1'b0}   // R5 descend
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [7:0] t);
        @(negedge clk); tgt_code = t; tgt_valid = 1'b1;
        @(negedge clk); tgt_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset code", speed_code, INIT);
        check("R1 reset done", at_target, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset code", speed_code, INIT);

        ticks(15);
        check("R2 idle code", speed_code, INIT);
        check("R2 idle done", at_target, 0);

        for (int r = 0; r < NROWS; r++) begin
            strobe(VEC[r][24:17]);
            ticks(int'(VEC[r][16:9]));
            check($sformatf("R3/R4/R5/R7/R8 row %0d code", r), speed_code, int'(VEC[r][8:1]));
            check($sformatf("R7 row %0d done", r), at_target, int'(VEC[r][0]));
        end

        // R9 upper end: climb from 6 to 255 then extra ticks
        strobe(8'd255);
        ticks(249 * 10);
        check("R9 top code", speed_code, 255);
        check("R7 top done", at_target, 1);
        ticks(30);
        check("R9 top hold", speed_code, 255);

        // R9 lower end
        strobe(8'd0);
        ticks(255 * 20);
        check("R9 bottom code", speed_code, 0);
        check("R7 bottom done", at_target, 1);
        ticks(50);
        check("R9 bottom hold", speed_code, 0);

        // R1 reset in mid-ramp
        strobe(8'd100);
        ticks(25);
        check("R4 mid ramp", speed_code, 2);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-ramp code", speed_code, INIT);
        check("R1 reset mid-ramp done", at_target, 0);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule